// File: doc/BRIEF.md
# Host-Loaded ATM Cell Insertion Buffer

This block lets a host processor inject whole ATM cells into a receive cell stream. The host writes each cell one byte at a time through a small register bus. The buffer keeps up to four complete 53-byte cells. It releases the oldest complete cell whenever the downstream stream signals an idle cell slot.

The host learns whether another cell fits in one of two ways. It can poll a room flag in the control register, or it can take an interrupt. A sticky status bit records every cell that has fully drained into the stream, and an enable bit decides whether that status drives the interrupt line. The host marks the first byte of each cell with a start-of-cell control bit. It can empty the buffer by writing a rising edge on a clear bit. The clear is useful once after power-up, but operation never depends on it.

The register bus has four word addresses:
- 0: control.
- 1: interrupt enable.
- 2: status, which clears when read.
- 3: byte data port.

Read data is combinational from the address. The stream side presents one byte per cycle with a valid strobe and a start-of-cell marker on byte 0.

Top module: `cellins_buf`

## Requirements
- R1: After reset, control (address 0) reads 0x0A, interrupt enable (address 1) reads 0x00 and status (address 2) reads 0x00. Both `irq` and `cell_valid` are 0.
- R2: Control bit 1 is a read-only room flag. It is 1 while fewer than four cell slots are occupied, where a slot holding a partly written cell counts as occupied, and 0 when all four are taken.
- R3: Writing control bit 0 as 1 makes the next byte written to address 3 the first byte of a new cell. Any write to address 3 clears bit 0 again. A start-marked byte while a cell is still open restarts that cell at byte 0. A byte written with no cell open and bit 0 clear is discarded.
- R4: A cell becomes eligible only once all 53 of its bytes are written. When `slot_idle` is high at a rising edge while no cell is being sent and a complete cell is waiting, the next cycle begins 53 consecutive cycles of `cell_valid`. The bytes come in write order, cells leave oldest first, and `cell_soc` is high on byte 0 only. A `slot_idle` seen while a cell is being sent is ignored.
- R5: A control write whose bit 2 is 1 while the stored bit 2 is 0 empties the buffer, drops any open cell and stops a cell that is being sent, without raising a status event. A write with bit 2 already 1 has no effect on the buffer. Bit 2 reads back as last written.
- R6: Status bit 4 is set at the end of the last byte of each sent cell and stays set until status is read. The read returns the value from before the clear. An event in the same cycle as the read wins.
- R7: Interrupt enable bit 4 gates the interrupt. `irq` equals status bit 4 AND enable bit 4.
- R8: A byte written to address 3 while the room flag is 0 and no cell is open is not stored. It sets status bit 0, which is sticky and clears on a status read.
- R9: Control bit 3 reads 1 and control bit 4 reads 0, and writes to either have no effect. Control bits 7 to 5 and every interrupt enable bit except bit 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears status when address 2) |
| host_addr | input | 2 | Register word address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Cell-insertion interrupt |
| slot_idle | input | 1 | Downstream idle cell slot available |
| cell_valid | output | 1 | Inserted byte present on `cell_data` |
| cell_soc | output | 1 | Marks byte 0 of an inserted cell |
| cell_data | output | 8 | Inserted cell byte |

## Verification
The bench targets the following cases, and what a faulty design would do in each:

- Fourth slot partly written: it must already count as full. A design that counts only complete cells would report room there and then lose the overflow byte silently.
- Stray bytes, restarted cells and half-written cells: output bytes are compared against an arithmetic pattern. A design that stored stray bytes, kept a stale partial cell, or launched a cell early would put misplaced bytes on the stream.
- Clear bit: it is written both as an edge and while held high, and once in the middle of a cell being sent. A level-sensitive clear would empty the buffer repeatedly, and a clear that ignores the sender would keep driving `cell_valid`.
- Interrupt: the bench checks that `irq` follows both the enable mask and the read-clear of the sticky status. An interrupt wired straight to the event, or a status bit that never clears, shows up as a wrong `irq` level.

// File: rtl/cellins_pkg.sv
package cellins_pkg;

   localparam int BYTE_W = 8;
   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      REG_CTRL = 2'd0,
      REG_IEN  = 2'd1,
      REG_STAT = 2'd2,
      REG_DATA = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int CTL_SOC  = 0;
   localparam int CTL_ROOM = 1;
   localparam int CTL_CLR  = 2;
   localparam int CTL_XRST = 3;
   localparam int CTL_XAV  = 4;

   // interrupt enable / status bit positions
   localparam int IEN_INS = 4;
   localparam int ST_INS  = 4;
   localparam int ST_OVF  = 0;

endpackage

// File: rtl/cellins_regs.sv
module cellins_regs
   import cellins_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [REG_AW-1:0]   host_addr,
   input  logic [BYTE_W-1:0]   host_wdata,
   output logic [BYTE_W-1:0]   host_rdata,
   input  logic                room,
   input  logic                ins_evt,
   input  logic                ovf_evt,
   output logic                soc_flag,
   output logic                clr_pulse,
   output logic                data_we,
   output logic [BYTE_W-1:0]   data_byte,
   output logic                irq
);

   logic clr_bit;
   logic ien_ins;
   logic ins_st;
   logic ovf_st;
   logic ctl_wr;
   logic ien_wr;
   logic st_rd;

   assign ctl_wr    = host_wr && (host_addr == REG_CTRL);
   assign ien_wr    = host_wr && (host_addr == REG_IEN);
   assign st_rd     = host_rd && (host_addr == REG_STAT);
   assign data_we   = host_wr && (host_addr == REG_DATA);
   assign data_byte = host_wdata;
   assign clr_pulse = ctl_wr && host_wdata[CTL_CLR] && !clr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soc_flag <= 1'b0;
         clr_bit  <= 1'b0;
         ien_ins  <= 1'b0;
      end else begin
         if (ctl_wr) begin
            soc_flag <= host_wdata[CTL_SOC];
            clr_bit  <= host_wdata[CTL_CLR];
         end else if (data_we) begin
            soc_flag <= 1'b0;
         end
         if (ien_wr) ien_ins <= host_wdata[IEN_INS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_st <= 1'b0;
         ovf_st <= 1'b0;
      end else begin
         if (ins_evt)    ins_st <= 1'b1;
         else if (st_rd) ins_st <= 1'b0;
         if (ovf_evt)    ovf_st <= 1'b1;
         else if (st_rd) ovf_st <= 1'b0;
      end
   end

   assign irq = ins_st & ien_ins;

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         REG_CTRL: begin
            host_rdata[CTL_SOC]  = soc_flag;
            host_rdata[CTL_ROOM] = room;
            host_rdata[CTL_CLR]  = clr_bit;
            host_rdata[CTL_XRST] = 1'b1;
            host_rdata[CTL_XAV]  = 1'b0;
         end
         REG_IEN:  host_rdata[IEN_INS] = ien_ins;
         REG_STAT: begin
            host_rdata[ST_INS] = ins_st;
            host_rdata[ST_OVF] = ovf_st;
         end
         default:  host_rdata = '0;
      endcase
   end

   // R7
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ins_evt) || $past(ien_wr)));

   // R6
   ins_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !ins_evt) |=> !ins_st);

   // R8
   ovf_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_st);

endmodule

// File: rtl/cellins_store.sv
module cellins_store
   import cellins_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int NUM_CELLS  = 4,
   localparam int IDX_W  = $clog2(CELL_BYTES),
   localparam int SLOT_W = $clog2(NUM_CELLS),
   localparam int CNT_W  = $clog2(NUM_CELLS + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               data_we,
   input  logic               soc_flag,
   input  logic [BYTE_W-1:0]  data_byte,
   input  logic               pop,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [BYTE_W-1:0]  rd_byte,
   output logic               room,
   output logic               cell_ready,
   output logic               ovf_evt
);

   localparam int DEPTH  = CELL_BYTES * NUM_CELLS;
   localparam int MEM_AW = $clog2(DEPTH);
   localparam int OCC_W  = CNT_W + 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [SLOT_W-1:0] wr_slot;
   logic [SLOT_W-1:0] rd_slot;
   logic [IDX_W-1:0]  wr_pos;
   logic              in_cell;
   logic [CNT_W-1:0]  full_cnt;
   logic [OCC_W-1:0]  occ;
   logic              acc_soc;
   logic              acc_cont;
   logic              push;
   logic              mem_we;
   logic [IDX_W-1:0]  wr_idx;
   logic [MEM_AW-1:0] wr_addr;
   logic [MEM_AW-1:0] rd_addr;

   assign occ        = OCC_W'(full_cnt) + OCC_W'(in_cell);
   assign room       = occ < OCC_W'(NUM_CELLS);
   assign cell_ready = (full_cnt != '0);

   always_comb begin
      acc_soc  = data_we && soc_flag && (in_cell || room);
      acc_cont = data_we && !soc_flag && in_cell;
      ovf_evt  = data_we && !in_cell && !room;
      push     = acc_cont && (wr_pos == LAST_IDX);
      mem_we   = (acc_soc || acc_cont) && !clr;
      wr_idx   = acc_soc ? '0 : wr_pos;
   end

   assign wr_addr = MEM_AW'(wr_slot) * MEM_AW'(CELL_BYTES) + MEM_AW'(wr_idx);
   assign rd_addr = MEM_AW'(rd_slot) * MEM_AW'(CELL_BYTES) + MEM_AW'(rd_idx);
   assign rd_byte = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (mem_we) mem[wr_addr] <= data_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         wr_pos   <= '0;
         in_cell  <= 1'b0;
         full_cnt <= '0;
      end else if (clr) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         wr_pos   <= '0;
         in_cell  <= 1'b0;
         full_cnt <= '0;
      end else begin
         if (acc_soc) begin
            in_cell <= 1'b1;
            wr_pos  <= IDX_W'(1);
         end else if (acc_cont) begin
            if (push) begin
               in_cell <= 1'b0;
               wr_pos  <= '0;
               wr_slot <= wr_slot + SLOT_W'(1);
            end else begin
               wr_pos  <= wr_pos + IDX_W'(1);
            end
         end
         if (pop) rd_slot <= rd_slot + SLOT_W'(1);
         unique case ({push, pop})
            2'b10:   full_cnt <= full_cnt + CNT_W'(1);
            2'b01:   full_cnt <= full_cnt - CNT_W'(1);
            default: full_cnt <= full_cnt;
         endcase
      end
   end

   // R2
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_cnt <= CNT_W'(NUM_CELLS));

   // R4
   pop_has_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (full_cnt != '0));

   // R5
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((full_cnt == '0) && !in_cell && room));

   // R8
   reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !clr) |=> ($stable(in_cell) && $stable(wr_pos)));

endmodule

// File: rtl/cellins_launch.sv
module cellins_launch #(
   parameter int CELL_BYTES = 53,
   localparam int IDX_W = $clog2(CELL_BYTES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              slot_idle,
   input  logic              cell_ready,
   output logic              busy,
   output logic              out_soc,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   assign out_soc = busy && (rd_idx == '0);
   assign done    = busy && (rd_idx == LAST_IDX) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rd_idx <= '0;
      end else if (clr) begin
         busy   <= 1'b0;
         rd_idx <= '0;
      end else if (!busy) begin
         if (slot_idle && cell_ready) begin
            busy   <= 1'b1;
            rd_idx <= '0;
         end
      end else if (rd_idx == LAST_IDX) begin
         busy   <= 1'b0;
         rd_idx <= '0;
      end else begin
         rd_idx <= rd_idx + IDX_W'(1);
      end
   end

   // R4
   start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(slot_idle) && $past(cell_ready)));

   // R4
   soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_soc |=> !out_soc);

endmodule

// File: rtl/cellins_buf.sv
module cellins_buf
   import cellins_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int NUM_CELLS  = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [REG_AW-1:0]  host_addr,
   input  logic [BYTE_W-1:0]  host_wdata,
   output logic [BYTE_W-1:0]  host_rdata,
   output logic               irq,
   input  logic               slot_idle,
   output logic               cell_valid,
   output logic               cell_soc,
   output logic [BYTE_W-1:0]  cell_data
);

   localparam int IDX_W = $clog2(CELL_BYTES);

   if (CELL_BYTES < 2) begin : g_bad_len
      $error("cellins_buf: CELL_BYTES must be at least 2");
   end
   if (NUM_CELLS < 2 || (NUM_CELLS & (NUM_CELLS - 1)) != 0) begin : g_bad_depth
      $error("cellins_buf: NUM_CELLS must be a power of two, at least 2");
   end

   logic              room;
   logic              soc_flag;
   logic              clr_pulse;
   logic              data_we;
   logic [BYTE_W-1:0] data_byte;
   logic              ovf_evt;
   logic              cell_ready;
   logic              done;
   logic              busy;
   logic [IDX_W-1:0]  rd_idx;
   logic [BYTE_W-1:0] rd_byte;

   cellins_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .room       (room),
      .ins_evt    (done),
      .ovf_evt    (ovf_evt),
      .soc_flag   (soc_flag),
      .clr_pulse  (clr_pulse),
      .data_we    (data_we),
      .data_byte  (data_byte),
      .irq        (irq)
   );

   cellins_store #(
      .CELL_BYTES (CELL_BYTES),
      .NUM_CELLS  (NUM_CELLS)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_pulse),
      .data_we    (data_we),
      .soc_flag   (soc_flag),
      .data_byte  (data_byte),
      .pop        (done),
      .rd_idx     (rd_idx),
      .rd_byte    (rd_byte),
      .room       (room),
      .cell_ready (cell_ready),
      .ovf_evt    (ovf_evt)
   );

   cellins_launch #(
      .CELL_BYTES (CELL_BYTES)
   ) u_launch (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_pulse),
      .slot_idle  (slot_idle),
      .cell_ready (cell_ready),
      .busy       (busy),
      .out_soc    (cell_soc),
      .rd_idx     (rd_idx),
      .done       (done)
   );

   assign cell_valid = busy;
   assign cell_data  = busy ? rd_byte : '0;

endmodule

// File: tb/cellins_buf_bench.sv
module cellins_buf_bench;
   import cellins_pkg::*;

   localparam int CB = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       irq;
   logic       slot_idle = 1'b0;
   logic       cell_valid;
   logic       cell_soc;
   logic [7:0] cell_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cellins_buf u_cellins_buf (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .slot_idle(slot_idle), .cell_valid(cell_valid),
      .cell_soc(cell_soc), .cell_data(cell_data)
   );

   function automatic logic [7:0] pat(input int s, input int i);
      return 8'((s * 37 + i * 5 + 1) & 255);
   endfunction

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic expect_reg(input logic [1:0] a, input int exp, input string req);
      int v;
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1 v = int'(host_rdata);
      @(negedge clk);
      host_rd = 1'b0;
      chk_eq(req, v, exp);
   endtask

   task automatic load_cell(input int s);
      wr_reg(REG_CTRL, 8'h01);
      for (int i = 0; i < CB; i++) wr_reg(REG_DATA, pat(s, i));
   endtask

   task automatic recv_cell(input int s, input bit poke, input string req);
      int bad;
      bad = 0;
      @(negedge clk); slot_idle = 1'b1;
      @(negedge clk); slot_idle = 1'b0;
      for (int i = 0; i < CB; i++) begin
         if (i > 0) @(negedge clk);
         slot_idle = poke && (i == 20);
         if (cell_valid !== 1'b1 || cell_soc !== (i == 0) || cell_data !== pat(s, i)) bad++;
      end
      @(negedge clk); slot_idle = 1'b0;
      chk_eq({req, " cell bytes"}, bad, 0);
      chk_eq({req, " valid after cell"}, int'(cell_valid), 0);
   endtask

   task automatic idle_probe(input string req);
      @(negedge clk); slot_idle = 1'b1;
      @(negedge clk); slot_idle = 1'b0;
      chk_eq(req, int'(cell_valid), 0);
      @(negedge clk);
      chk_eq(req, int'(cell_valid), 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg(REG_CTRL, 8'h0A, "R1 ctrl");
      expect_reg(REG_IEN,  8'h00, "R1 ien");
      expect_reg(REG_STAT, 8'h00, "R1 stat");
      chk_eq("R1 irq", int'(irq), 0);
      chk_eq("R1 cell_valid", int'(cell_valid), 0);

      // R9 constant and unused bits
      wr_reg(REG_CTRL, 8'hF8);
      expect_reg(REG_CTRL, 8'h0A, "R9 ctrl constants");
      wr_reg(REG_IEN, 8'hEF);
      expect_reg(REG_IEN, 8'h00, "R9 ien others");
      wr_reg(REG_IEN, 8'hFF);
      expect_reg(REG_IEN, 8'h10, "R9 ien bit4 only");
      wr_reg(REG_IEN, 8'h00);

      // R3 stray bytes discarded, no overflow
      repeat (3) wr_reg(REG_DATA, 8'h55);
      expect_reg(REG_STAT, 8'h00, "R3 stray no ovf");

      // R3 start flag readback and self clear
      wr_reg(REG_CTRL, 8'h01);
      expect_reg(REG_CTRL, 8'h0B, "R3 soc flag set");
      wr_reg(REG_DATA, pat(1, 0));
      expect_reg(REG_CTRL, 8'h0A, "R3 soc flag cleared");
      for (int i = 1; i < CB; i++) wr_reg(REG_DATA, pat(1, i));
      load_cell(2);
      load_cell(3);
      expect_reg(REG_CTRL, 8'h0A, "R2 room with three cells");
      wr_reg(REG_CTRL, 8'h01);
      wr_reg(REG_DATA, pat(4, 0));
      expect_reg(REG_CTRL, 8'h08, "R2 partial cell occupies");
      for (int i = 1; i < CB; i++) wr_reg(REG_DATA, pat(4, i));
      expect_reg(REG_CTRL, 8'h08, "R2 full");

      // R8 overflow
      wr_reg(REG_CTRL, 8'h01);
      wr_reg(REG_DATA, 8'h77);
      expect_reg(REG_STAT, 8'h01, "R8 ovf set");
      expect_reg(REG_STAT, 8'h00, "R8 ovf read clear");
      wr_reg(REG_DATA, 8'h66);
      expect_reg(REG_STAT, 8'h01, "R8 ovf stray");
      expect_reg(REG_CTRL, 8'h08, "R8 still full");

      // R4 / R7 insertion and interrupt
      wr_reg(REG_IEN, 8'h10);
      chk_eq("R7 irq before insert", int'(irq), 0);
      recv_cell(1, 1'b1, "R4 first cell");
      chk_eq("R7 irq after insert", int'(irq), 1);
      expect_reg(REG_CTRL, 8'h0A, "R2 room regained");
      recv_cell(2, 1'b0, "R4 fifo order");
      chk_eq("R6 sticky irq", int'(irq), 1);
      expect_reg(REG_STAT, 8'h10, "R6 ins status");
      chk_eq("R6 irq after read", int'(irq), 0);
      expect_reg(REG_STAT, 8'h00, "R6 status cleared");
      wr_reg(REG_IEN, 8'h00);
      recv_cell(3, 1'b0, "R4 third cell");
      chk_eq("R7 masked irq", int'(irq), 0);
      expect_reg(REG_STAT, 8'h10, "R6 status while masked");
      recv_cell(4, 1'b0, "R4 fourth cell");
      idle_probe("R4 empty buffer");

      // R3 restart of an open cell
      wr_reg(REG_CTRL, 8'h01);
      for (int i = 0; i < 10; i++) wr_reg(REG_DATA, pat(8, i));
      load_cell(9);
      recv_cell(9, 1'b0, "R3 restarted cell");

      // R4 partial cell not eligible
      wr_reg(REG_CTRL, 8'h01);
      for (int i = 0; i < CB - 1; i++) wr_reg(REG_DATA, pat(10, i));
      idle_probe("R4 partial not sent");
      wr_reg(REG_DATA, pat(10, CB - 1));
      recv_cell(10, 1'b0, "R4 completed cell");

      // R5 clear by rising edge
      load_cell(11);
      load_cell(12);
      wr_reg(REG_CTRL, 8'h04);
      expect_reg(REG_CTRL, 8'h0E, "R5 clr bit readback");
      idle_probe("R5 cleared buffer");
      wr_reg(REG_CTRL, 8'h05);
      for (int i = 0; i < CB; i++) wr_reg(REG_DATA, pat(13, i));
      wr_reg(REG_CTRL, 8'h04);
      recv_cell(13, 1'b0, "R5 held bit no clear");
      expect_reg(REG_STAT, 8'h10, "R6 status before clear test");

      // R5 clear during sending
      load_cell(14);
      @(negedge clk); slot_idle = 1'b1;
      @(negedge clk); slot_idle = 1'b0;
      repeat (5) @(negedge clk);
      chk_eq("R5 sending before clear", int'(cell_valid), 1);
      wr_reg(REG_CTRL, 8'h04);
      chk_eq("R5 send stopped", int'(cell_valid), 0);
      expect_reg(REG_STAT, 8'h00, "R5 no event on clear");
      idle_probe("R5 nothing left");
      load_cell(15);
      recv_cell(15, 1'b0, "R5 usable after clear");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule